// File: doc/BRIEF.md
# Auto-Ranging Clock Frequency Meter Sequencer

This block turns one request to measure an internal clock into a finished frequency reading. It controls a separate gated counting unit through a simple register master port. The counting unit counts edges of the selected clock during a gate window given in microseconds. The sequencer starts with the longest window, which gives the finest resolution. Whenever the count saturates, it shortens the window and tries again. It stops at the first reading that does not saturate.

Each attempt programs the counting unit in a fixed order, waits for it to finish and reads the count. The count is then scaled to hertz with rounding, using an iterative divider. The sequencer also reports the resolution of the window that produced the reading. When the counter keeps saturating down to the shortest window, or the unit never drops its busy flag, the sequencer reports an error instead.

Top module: `freq_autorange`

## Requirements
- R1: After reset, `freq_hz`, `prec_hz`, `valid` and `err` are zero, and neither `bus_wr` nor `bus_rd` is asserted until a start is accepted.
- R2: An accepted start triggers attempts that each write the control word (word index 1) four times, one write per cycle, starting in the cycle after acceptance. The four writes are, in order:
  - zero;
  - (duration − 1) in bits 15:0;
  - the same value with the 7-bit clock ID added in bits 26:20;
  - the same value with the enable bit 16 and the run bit 19 both set.
- R3: The first attempt after a start uses a 640 µs window, so its duration field is 639.
- R4: After the launch write, the sequencer reads the control word until bit 31 (busy) is low. It then writes the control word again with bit 16 cleared. Finally it reads the count from word index 3. Reads return their data in the cycle after the read strobe, and read and write strobes are never active together.
- R5: A count of 0xFFFF or more means overflow. On overflow the window shrinks by 32 µs and a complete new attempt follows, starting with the zero write.
- R6: If the attempt at 32 µs also overflows, `err` pulses for one cycle, `valid` stays low, and the run has made exactly 20 attempts.
- R7: On success, `valid` pulses for one cycle and `freq_hz` = (count × 1,000,000 + duration/2) / duration, truncated. This is the nearest-integer rounding of count × 10^6 / duration, with halves rounding up.
- R8: On success, `prec_hz` = 2,000,000 / duration (truncated), where duration is the window of the successful attempt.
- R9: While busy stays high, the busy flag is re-read at intervals of at least POLL_US × TICKS_PER_US cycles. After the first read there are at most TIMEOUT_US / POLL_US re-reads. If busy is still high after the last one, `err` pulses and no count read follows.
- R10: A start request while a measurement is in progress is ignored. The clock ID already programmed and the result are unchanged.
- R11: An accepted start clears `freq_hz` and `prec_hz` to zero. Otherwise they change only in the cycle where `valid` pulses. A start presented in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a measurement (taken when idle) |
| clk_id | input | ID_W | Clock source to measure |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_addr | output | 2 | Register word index |
| bus_wdata | output | 32 | Register write data |
| bus_rdata | input | 32 | Register read data, valid the cycle after `bus_rd` |
| freq_hz | output | FREQ_W | Measured frequency in Hz |
| prec_hz | output | FREQ_W | Resolution of the reading in Hz |
| valid | output | 1 | One-cycle pulse: a reading is ready |
| err | output | 1 | One-cycle pulse: overflow at all windows or busy timeout |

## Verification
Completion of one measurement and acceptance of the next can happen in the same cycle. This is because `valid` is raised as the sequencer returns to idle. The bench raises `start` with a new clock ID during the very cycle in which `valid` is high. It then checks three things:
- the reading on the outputs in that cycle is correct;
- both outputs read zero one cycle later;
- a fresh attempt begins with the zero write and carries the new ID, and its result is correct.

A second overlap is a start arriving mid-measurement. The bench judges it by the clock ID field in the source write and by the number of launch writes.

// File: rtl/freq_autorange_pkg.sv
package freq_autorange_pkg;
    // Register word indices on the master port
    localparam logic [1:0] CTRL_IDX = 2'd1;
    localparam logic [1:0] CNT_IDX  = 2'd3;
    // Control word bit positions decoded by the counting unit
    localparam int EN_BIT   = 16;
    localparam int RUN_BIT  = 19;
    localparam int SRC_LSB  = 20;
    localparam int BUSY_BIT = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_WCLR, S_WDUR, S_WSRC, S_WGO,
        S_RBUSY, S_RBUSY_W, S_WAIT, S_WDIS,
        S_RCNT, S_RCNT_W, S_DIVF, S_DIVP
    } seq_state_t;
endpackage

// File: rtl/seq_divider.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes divisor is non-zero; 'done' pulses N cycles after 'go'.
module seq_divider #(
    parameter int N   = 37,
    parameter int DW  = 10,
    parameter int Q_W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [N-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [Q_W-1:0] quotient
);
    localparam int CW = $clog2(N + 1);

    logic [N-1:0]  quo_q;
    logic [DW-1:0] rem_q, dvs_q, rem_n;
    logic [CW-1:0] cnt_q;
    logic          run_q, bit_n;
    logic [DW:0]   shifted;

    // One trial subtraction step
    always_comb begin
        shifted = {rem_q, quo_q[N-1]};
        if (shifted >= {1'b0, dvs_q}) begin
            rem_n = DW'(shifted - {1'b0, dvs_q});
            bit_n = 1'b1;
        end else begin
            rem_n = shifted[DW-1:0];
            bit_n = 1'b0;
        end
    end

    // Load operands on go, then iterate N steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo_q <= '0; rem_q <= '0; dvs_q <= '0;
            cnt_q <= '0; run_q <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CW'(N);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_n;
                quo_q <= {quo_q[N-2:0], bit_n};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q[Q_W-1:0];
endmodule

// File: rtl/poll_timer.sv
// Countdown between busy polls. 'expire' is high for one cycle
// INTERVAL cycles after 'arm'. Assumes INTERVAL >= 1.
module poll_timer #(
    parameter int INTERVAL = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic expire
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign expire = run_q && (cnt_q == '0);

    // Reload on arm, count down while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (arm) begin
            cnt_q <= CW'(INTERVAL - 1);
            run_q <= 1'b1;
        end else if (expire) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/freq_autorange.sv
// Auto-ranging measurement sequencer. Drives a gated edge counter through
// a register master port, shrinking the gate on saturation, then scales
// the count to Hz and reports resolution. Assumes the counter unit answers
// reads one cycle after the strobe and accepts writes without wait states.
module freq_autorange
    import freq_autorange_pkg::*;
#(
    parameter int ID_W         = 7,
    parameter int CNT_W        = 16,
    parameter int FREQ_W       = 32,
    parameter int DUR_MAX      = 640,
    parameter int DUR_MIN      = 32,
    parameter int DUR_STEP     = 32,
    parameter int TICKS_PER_US = 250,
    parameter int POLL_US      = 10,
    parameter int TIMEOUT_US   = 10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ID_W-1:0]   clk_id,
    output logic              bus_wr,
    output logic              bus_rd,
    output logic [1:0]        bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    output logic [FREQ_W-1:0] freq_hz,
    output logic [FREQ_W-1:0] prec_hz,
    output logic              valid,
    output logic              err
);
    localparam int    DUR_W     = $clog2(DUR_MAX + 1);
    localparam int    SCALE     = 1_000_000;
    localparam int    SCALE_W   = $clog2(SCALE);
    localparam int    DIVD_W    = CNT_W + SCALE_W + 1;
    localparam int    INTERVAL  = POLL_US * TICKS_PER_US;
    localparam int    MAX_POLLS = TIMEOUT_US / POLL_US;
    localparam int    POLL_W    = $clog2(MAX_POLLS + 1);
    localparam logic [31:0] CNT_SAT = 32'((64'd1 << CNT_W) - 1);

    seq_state_t        st;
    logic [ID_W-1:0]   id_q;
    logic [DUR_W-1:0]  dur_q;
    logic [31:0]       ctrl_q;
    logic [POLL_W-1:0] poll_q;
    logic [FREQ_W-1:0] ftmp_q, quo;
    logic              seq_idle, ovf, busy_bit, last_poll;
    logic              tmr_arm, tmr_exp, div_go, div_done;
    logic [DIVD_W-1:0] dividend;

    assign seq_idle  = (st == S_IDLE);
    assign ovf       = (bus_rdata >= CNT_SAT);
    assign busy_bit  = bus_rdata[BUSY_BIT];
    assign last_poll = (poll_q == POLL_W'(MAX_POLLS));
    assign tmr_arm   = (st == S_RBUSY_W) && busy_bit && !last_poll;
    assign div_go    = ((st == S_RCNT_W) && !ovf) || ((st == S_DIVF) && div_done);

    // Dividend: rounded count scaling, or the fixed resolution numerator
    always_comb begin
        if (st == S_RCNT_W)
            dividend = DIVD_W'(bus_rdata[CNT_W-1:0]) * DIVD_W'(SCALE)
                     + DIVD_W'(dur_q >> 1);
        else
            dividend = DIVD_W'(2 * SCALE);
    end

    // Register port drive, decoded from the current state
    always_comb begin
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_addr  = CTRL_IDX;
        bus_wdata = '0;
        case (st)
            S_WCLR:  bus_wr = 1'b1;
            S_WDUR:  begin bus_wr = 1'b1; bus_wdata = 32'(dur_q - DUR_W'(1)); end
            S_WSRC:  begin bus_wr = 1'b1; bus_wdata = ctrl_q | (32'(id_q) << SRC_LSB); end
            S_WGO:   begin
                bus_wr    = 1'b1;
                bus_wdata = ctrl_q | (32'd1 << EN_BIT) | (32'd1 << RUN_BIT);
            end
            S_WDIS:  begin bus_wr = 1'b1; bus_wdata = ctrl_q & ~(32'd1 << EN_BIT); end
            S_RBUSY: bus_rd = 1'b1;
            S_RCNT:  begin bus_rd = 1'b1; bus_addr = CNT_IDX; end
            default: ;
        endcase
    end

    // Sequencer: attempt order, range search, conversion and reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; id_q <= '0; dur_q <= '0; ctrl_q <= '0; poll_q <= '0;
            ftmp_q <= '0; freq_hz <= '0; prec_hz <= '0; valid <= 1'b0; err <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (bus_wr) ctrl_q <= bus_wdata;
            case (st)
                S_IDLE: if (start) begin
                    id_q    <= clk_id;
                    dur_q   <= DUR_W'(DUR_MAX);
                    freq_hz <= '0;
                    prec_hz <= '0;
                    st      <= S_WCLR;
                end
                S_WCLR: st <= S_WDUR;
                S_WDUR: st <= S_WSRC;
                S_WSRC: st <= S_WGO;
                S_WGO:  begin poll_q <= '0; st <= S_RBUSY; end
                S_RBUSY: st <= S_RBUSY_W;
                S_RBUSY_W: begin
                    if (!busy_bit) st <= S_WDIS;
                    else if (last_poll) begin err <= 1'b1; st <= S_IDLE; end
                    else begin poll_q <= poll_q + 1'b1; st <= S_WAIT; end
                end
                S_WAIT: if (tmr_exp) st <= S_RBUSY;
                S_WDIS: st <= S_RCNT;
                S_RCNT: st <= S_RCNT_W;
                S_RCNT_W: begin
                    if (!ovf) st <= S_DIVF;
                    else if (dur_q < DUR_W'(DUR_MIN + DUR_STEP)) begin
                        err <= 1'b1;
                        st  <= S_IDLE;
                    end else begin
                        dur_q <= dur_q - DUR_W'(DUR_STEP);
                        st    <= S_WCLR;
                    end
                end
                S_DIVF: if (div_done) begin ftmp_q <= quo; st <= S_DIVP; end
                S_DIVP: if (div_done) begin
                    freq_hz <= ftmp_q;
                    prec_hz <= quo;
                    valid   <= 1'b1;
                    st      <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    poll_timer #(.INTERVAL(INTERVAL)) u_tmr (
        .clk(clk), .rst_n(rst_n), .arm(tmr_arm), .expire(tmr_exp)
    );

    seq_divider #(.N(DIVD_W), .DW(DUR_W), .Q_W(FREQ_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(dividend),
        .divisor(dur_q), .done(div_done), .quotient(quo)
    );
endmodule

// File: rtl/freq_autorange_chk.sv
// Temporal checks on the sequencer's ports, attached by bind.
module freq_autorange_chk #(
    parameter int FREQ_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              seq_idle,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [FREQ_W-1:0] freq_hz,
    input logic [FREQ_W-1:0] prec_hz,
    input logic              valid,
    input logic              err
);
    // R7: success and error never reported together
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && err));

    // R7: valid is a single-cycle pulse
    p_vpulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6: err is a single-cycle pulse
    p_epulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R4: read and write strobes are exclusive
    p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    // R2: an accepted start is followed by the clearing write
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seq_idle) |=> (bus_wr && bus_addr == 2'd1 && bus_wdata == 32'd0));

    // R11: results hold unless a start was accepted or valid is reported
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start && seq_idle) && !valid) |-> ($stable(freq_hz) && $stable(prec_hz)));
endmodule

bind freq_autorange freq_autorange_chk #(.FREQ_W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_idle(seq_idle),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .freq_hz(freq_hz), .prec_hz(prec_hz), .valid(valid), .err(err)
);

// File: tb/freq_autorange_tb.sv
`timescale 1ns/1ps
module freq_autorange_tb;
    localparam int POLL_US = 10, TIMEOUT_US = 10000, TPU = 1;
    localparam int MAXP = TIMEOUT_US / POLL_US;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [6:0] clk_id = '0;
    logic bus_wr, bus_rd, valid, err;
    logic [1:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic [31:0] freq_hz, prec_hz;

    always #2 clk = ~clk;

    freq_autorange #(.TICKS_PER_US(TPU), .POLL_US(POLL_US), .TIMEOUT_US(TIMEOUT_US)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_id(clk_id),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .freq_hz(freq_hz), .prec_hz(prec_hz),
        .valid(valid), .err(err)
    );

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;

    // Counting-unit model state
    longint model_f = 0;
    int busy_lat = 25, busy_left = 0, phase = 0;
    bit stuck = 0;
    logic [31:0] m_ctrl = '0;
    int attempts = 0, seq_bad = 0, ctrl_reads = 0, first_field = -1, last_src = -1, bus_seen = 0;
    longint go_cyc = 0;

    function automatic longint cnt_for(input longint d);
        longint c = model_f * d / 1000000;
        if (c > 65535) c = 65535;
        return c;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model of the counting unit: register file, busy timer, order check
    always @(posedge clk) begin
        cyc++;
        if (bus_wr || bus_rd) bus_seen++;
        if (busy_left > 0) busy_left--;
        if (bus_rd) begin
            if (bus_addr == 2'd1) begin
                ctrl_reads++;
                bus_rdata <= m_ctrl | ((stuck || busy_left > 0) ? 32'h8000_0000 : 32'h0);
            end else if (bus_addr == 2'd3) begin
                if (phase != 5) seq_bad++;
                phase = 0;
                bus_rdata <= 32'(cnt_for(longint'(m_ctrl[15:0]) + 1));
            end else bus_rdata <= '0;
        end
        if (bus_wr) begin
            if (bus_addr != 2'd1) seq_bad++;
            case (phase)
                0: begin if (bus_wdata != 0) seq_bad++; phase = 1; end
                1: begin
                    if (bus_wdata[31:16] != 0) seq_bad++;
                    if (first_field < 0) first_field = int'(bus_wdata[15:0]);
                    phase = 2;
                end
                2: begin
                    if (bus_wdata[15:0] != m_ctrl[15:0] || bus_wdata[19:16] != 0) seq_bad++;
                    last_src = int'(bus_wdata[26:20]);
                    phase = 3;
                end
                3: begin
                    if (!bus_wdata[16] || !bus_wdata[19] || bus_wdata[26:0] != (m_ctrl[26:0] | 27'h09_0000)) seq_bad++;
                    attempts++;
                    busy_left = busy_lat;
                    go_cyc = cyc;
                    ctrl_reads = 0;
                    phase = 4;
                end
                4: begin
                    if (busy_left > 0 || stuck || bus_wdata[16] || !bus_wdata[19]) seq_bad++;
                    phase = 5;
                end
                default: seq_bad++;
            endcase
            m_ctrl = bus_wdata;
        end
    end

    // Expected outcome from the requirements
    task automatic expect_for(output bit ok, output longint f, output longint p, output int att);
        ok = 0; f = 0; p = 0; att = 0;
        for (int d = 640; d >= 32; d -= 32) begin
            longint c = cnt_for(d);
            att++;
            if (c < 65535) begin
                ok = 1;
                f = (c * 1000000 + d / 2) / d;
                p = 2000000 / d;
                break;
            end
        end
    endtask

    logic got_v, got_e;
    int v_cnt;
    longint r_freq, r_prec, end_cyc;

    task automatic prep(input longint f, input int lat, input bit stk);
        model_f = f; busy_lat = lat; stuck = stk;
        phase = 0; attempts = 0; seq_bad = 0; first_field = -1; last_src = -1;
    endtask

    task automatic pulse_start(input logic [6:0] id);
        @(negedge clk); start = 1'b1; clk_id = id;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        got_v = 0; got_e = 0; v_cnt = 0;
        for (int i = 0; i < 30000 && !got_v && !got_e; i++) begin
            if (valid) begin got_v = 1; v_cnt++; r_freq = freq_hz; r_prec = prec_hz; end
            if (err) begin got_e = 1; end_cyc = cyc; end
            if (!got_v && !got_e) @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin @(negedge clk); if (valid) v_cnt++; end
    endtask

    task automatic t_reset();
        check(freq_hz == 0 && prec_hz == 0, "R1 outputs after reset", freq_hz, 0);
        check(!valid && !err, "R1 pulses after reset", {valid, err}, 0);
        check(bus_seen == 0, "R1 no bus access", bus_seen, 0);
    endtask

    task automatic t_measure(input string nm, input logic [6:0] id, input longint f);
        bit eok; longint ef, ep; int eat;
        prep(f, 25, 0);
        expect_for(eok, ef, ep, eat);
        pulse_start(id);
        wait_done();
        check(got_v && !got_e, {nm, " R7 valid"}, got_v, 1);
        check(v_cnt == 1, {nm, " R7 single pulse"}, v_cnt, 1);
        check(r_freq == ef, {nm, " R7 freq"}, r_freq, ef);
        check(r_prec == ep, {nm, " R8 prec"}, r_prec, ep);
        check(attempts == eat, {nm, " R5 attempts"}, attempts, eat);
        check(first_field == 639, {nm, " R3 first duration field"}, first_field, 639);
        check(last_src == int'(id), {nm, " R2 source id"}, last_src, id);
        check(seq_bad == 0, {nm, " R2 R4 write/read order"}, seq_bad, 0);
        check(freq_hz == ef && prec_hz == ep, {nm, " R11 hold"}, freq_hz, ef);
    endtask

    task automatic t_all_overflow();
        prep(64'd3_000_000_000, 5, 0);
        pulse_start(7'd12);
        wait_done();
        check(got_e && !got_v, "R6 error on overflow at minimum", got_e, 1);
        check(attempts == 20, "R6 attempt count", attempts, 20);
        check(seq_bad == 0, "R5 retry order", seq_bad, 0);
    endtask

    task automatic t_timeout();
        prep(64'd50_000_000, 5, 1);
        pulse_start(7'd2);
        wait_done();
        check(got_e && !got_v, "R9 timeout error", got_e, 1);
        check(ctrl_reads == MAXP + 1, "R9 busy reads", ctrl_reads, MAXP + 1);
        check(end_cyc - go_cyc >= longint'(MAXP * POLL_US * TPU), "R9 elapsed", end_cyc - go_cyc, MAXP * POLL_US * TPU);
        check(phase == 4, "R9 no disable or count read", phase, 4);
        stuck = 0;
    endtask

    task automatic t_ignore_busy();
        prep(64'd50_000_000, 40, 0);
        pulse_start(7'd5);
        repeat (3) @(negedge clk);
        pulse_start(7'd9);
        repeat (20) @(negedge clk);
        pulse_start(7'd10);
        wait_done();
        check(attempts == 1, "R10 one launch", attempts, 1);
        check(last_src == 5, "R10 id unchanged", last_src, 5);
        check(r_freq == 50_000_000, "R10 result unchanged", r_freq, 50_000_000);
    endtask

    task automatic t_back_to_back();
        int i;
        prep(64'd50_000_000, 10, 0);
        pulse_start(7'd3);
        for (i = 0; i < 30000 && !valid; i++) @(negedge clk);
        check(valid && freq_hz == 50_000_000, "R11 reading in valid cycle", freq_hz, 50_000_000);
        model_f = 64'd20_000_000; attempts = 0; first_field = -1;
        start = 1'b1; clk_id = 7'd4;
        @(negedge clk); start = 1'b0;
        check(freq_hz == 0 && prec_hz == 0, "R11 cleared on accepted start", freq_hz, 0);
        wait_done();
        check(got_v && r_freq == 20_000_000, "R11 second reading", r_freq, 20_000_000);
        check(last_src == 4 && attempts == 1, "R11 new id launched", last_src, 4);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_measure("exact", 7'd7, 64'd50_000_000);
        t_measure("retry", 7'd33, 64'd123_456_789);
        t_measure("round", 7'd127, 64'd7_777_777);
        t_all_overflow();
        t_timeout();
        t_ignore_busy();
        t_back_to_back();
        report();
    end
endmodule